// File: doc/BRIEF.md
# Serial Memory Slave Address Decoder

This block judges the first byte a host sends after each start condition on a two-wire serial memory bus. A bit-level front end deserializes the line and hands over whole bytes with a one-cycle valid strobe, along with single-cycle start and stop indications. The decoder splits the byte into a four-bit control code, a three-bit strap address and a read/write flag. It then decides whether the device answers, and which internal target the rest of the transfer addresses: the memory array or the one-time write-protect register.

The decision is also how a host polls for the end of a write. While the nonvolatile write cycle runs, every address byte is refused. The host repeats start-plus-address until it sees an acknowledge. Once the protect register has been programmed, the protect control code is refused for good. After a refusal the decoder stays in standby and ignores traffic until the next start. A stop, or a repeated start, closes whatever session was open.

Top module: `ee_addr_decoder`

## Requirements
- R1: After reset, ack_vld is 0, ack_n is 1, tgt_sel is 2'b00 (none) and op_rd is 0.
- R2: The address byte is laid out as bits [7:4] control code, bits [3:1] strap address and bit [0] read/write (1 = read). The decision appears as a one-cycle ack_vld pulse in the clock after the accepted byte_vld, and ack_n carries 0 for acknowledge and 1 for refuse.
- R3: Code 4'b1010 with a matching strap is acknowledged, sets tgt_sel to 2'b01 (memory) and sets op_rd to the read/write bit.
- R4: A strap field that differs from the strap pins is refused, and tgt_sel stays 2'b00.
- R5: Code 4'b0110 with the read/write bit 0, a matching strap and prot_set low is acknowledged, with tgt_sel 2'b10 (protect register) and op_rd 0. The same code with the read/write bit 1 is refused.
- R6: Code 4'b0110 is refused while prot_set is high.
- R7: While wr_busy is high, every address byte is refused, whatever its content.
- R8: Any control code other than 4'b1010 or 4'b0110 is refused.
- R9: A stop clears tgt_sel and op_rd, and bytes that arrive after it, before any new start, produce no ack_vld. A start in the same cycle as byte_vld reopens address waiting and discards that byte.
- R10: Only the first byte after a start is decoded. Later bytes in the same session, accepted or refused, produce no ack_vld and leave tgt_sel and op_rd unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | One-cycle pulse: start or repeated start seen |
| stop_det | input | 1 | One-cycle pulse: stop seen |
| byte_vld | input | 1 | One-cycle pulse: byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| strap | input | 3 | Hard-wired device address pins |
| wr_busy | input | 1 | Internal nonvolatile write cycle in progress |
| prot_set | input | 1 | Protect register already programmed |
| ack_vld | output | 1 | Decision pulse, one clock after the decoded byte |
| ack_n | output | 1 | 0 = acknowledge, 1 = refuse; meaningful with ack_vld |
| tgt_sel | output | 2 | 00 none, 01 memory, 10 protect register |
| op_rd | output | 1 | Acknowledged operation is a read |

## Verification
On every cycle, the assertions check the following. Each decision pulse traces back to a byte strobe one clock earlier. A busy cycle or a programmed protect register never yields an acknowledge to the affected codes. Every acknowledge matched the strap pins and a legal code, and carries the byte's direction bit. Start and stop leave no decision and no target behind. The bench's scenarios show the rest: the full sweep of byte values against strap settings, busy and protect flags; the standby that persists after a refusal; the discarding of a byte that collides with a start; and the silence toward data bytes later in a session.

// File: rtl/ead_pkg.sv
package ead_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_MEM  = 2'b01,
        TGT_PROT = 2'b10
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ADDR = 2'b01,
        ST_OPEN = 2'b10,
        ST_SKIP = 2'b11
    } state_e;

    typedef struct packed {
        logic hit;
        tgt_e tgt;
        logic rd;
    } verdict_t;

    localparam int DEF_CODE_W  = 4;
    localparam int DEF_STRAP_W = 3;
    localparam logic [3:0] DEF_MEM_CODE  = 4'b1010;
    localparam logic [3:0] DEF_PROT_CODE = 4'b0110;

    function automatic verdict_t refuse();
        verdict_t v;
        v.hit = 1'b0;
        v.tgt = TGT_NONE;
        v.rd  = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/ead_classify.sv
module ead_classify #(
    parameter int CODE_W  = ead_pkg::DEF_CODE_W,
    parameter int STRAP_W = ead_pkg::DEF_STRAP_W,
    parameter logic [CODE_W-1:0] MEM_CODE  = ead_pkg::DEF_MEM_CODE,
    parameter logic [CODE_W-1:0] PROT_CODE = ead_pkg::DEF_PROT_CODE,
    localparam int BYTE_W = CODE_W + STRAP_W + 1
) (
    input  logic [BYTE_W-1:0]  byte_data,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_busy,
    input  logic               prot_set,
    output ead_pkg::verdict_t  verdict
);
    import ead_pkg::*;

    logic [CODE_W-1:0]  code_f;
    logic [STRAP_W-1:0] strap_f;
    logic               rw_f;
    logic               strap_ok;
    logic               is_mem;
    logic               is_prot;

    assign code_f   = byte_data[BYTE_W-1 -: CODE_W];
    assign strap_f  = byte_data[STRAP_W:1];
    assign rw_f     = byte_data[0];
    assign strap_ok = (strap_f == strap);
    assign is_mem   = (code_f == MEM_CODE);
    assign is_prot  = (code_f == PROT_CODE);

    always_comb begin
        verdict = refuse();
        if (!wr_busy && strap_ok) begin
            if (is_mem) begin
                verdict.hit = 1'b1;
                verdict.tgt = TGT_MEM;
                verdict.rd  = rw_f;
            end else if (is_prot && !rw_f && !prot_set) begin
                verdict.hit = 1'b1;
                verdict.tgt = TGT_PROT;
                verdict.rd  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ead_fsm.sv
module ead_fsm (
    input  logic clk,
    input  logic rst,
    input  logic start_det,
    input  logic stop_det,
    input  logic byte_vld,
    input  logic hit,
    output logic decide,
    output logic sess_clr
);
    import ead_pkg::*;

    state_e state_q;
    state_e state_d;

    assign sess_clr = start_det | stop_det;
    assign decide   = (state_q == ST_ADDR) && byte_vld && !sess_clr;

    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else if (decide) begin
            state_d = hit ? ST_OPEN : ST_SKIP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/ead_resp_reg.sv
module ead_resp_reg (
    input  logic              clk,
    input  logic              rst,
    input  logic              decide,
    input  logic              sess_clr,
    input  ead_pkg::verdict_t verdict,
    output logic              ack_vld,
    output logic              ack_n,
    output ead_pkg::tgt_e     tgt,
    output logic              op_rd
);
    import ead_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_vld <= 1'b0;
            ack_n   <= 1'b1;
            tgt     <= TGT_NONE;
            op_rd   <= 1'b0;
        end else if (sess_clr) begin
            ack_vld <= 1'b0;
            ack_n   <= 1'b1;
            tgt     <= TGT_NONE;
            op_rd   <= 1'b0;
        end else if (decide) begin
            ack_vld <= 1'b1;
            ack_n   <= !verdict.hit;
            tgt     <= verdict.tgt;
            op_rd   <= verdict.rd;
        end else begin
            ack_vld <= 1'b0;
            ack_n   <= 1'b1;
        end
    end
endmodule

// File: rtl/ee_addr_decoder.sv
module ee_addr_decoder #(
    parameter int CODE_W  = ead_pkg::DEF_CODE_W,
    parameter int STRAP_W = ead_pkg::DEF_STRAP_W,
    parameter logic [CODE_W-1:0] MEM_CODE  = ead_pkg::DEF_MEM_CODE,
    parameter logic [CODE_W-1:0] PROT_CODE = ead_pkg::DEF_PROT_CODE,
    localparam int BYTE_W = CODE_W + STRAP_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_data,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_busy,
    input  logic               prot_set,
    output logic               ack_vld,
    output logic               ack_n,
    output logic [1:0]         tgt_sel,
    output logic               op_rd
);
    import ead_pkg::*;

    verdict_t verdict;
    logic     decide;
    logic     sess_clr;
    tgt_e     tgt;

    ead_classify #(
        .CODE_W   (CODE_W),
        .STRAP_W  (STRAP_W),
        .MEM_CODE (MEM_CODE),
        .PROT_CODE(PROT_CODE)
    ) u_classify (
        .byte_data(byte_data),
        .strap    (strap),
        .wr_busy  (wr_busy),
        .prot_set (prot_set),
        .verdict  (verdict)
    );

    ead_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_det(start_det),
        .stop_det (stop_det),
        .byte_vld (byte_vld),
        .hit      (verdict.hit),
        .decide   (decide),
        .sess_clr (sess_clr)
    );

    ead_resp_reg u_resp (
        .clk     (clk),
        .rst     (rst),
        .decide  (decide),
        .sess_clr(sess_clr),
        .verdict (verdict),
        .ack_vld (ack_vld),
        .ack_n   (ack_n),
        .tgt     (tgt),
        .op_rd   (op_rd)
    );

    assign tgt_sel = tgt;
endmodule

// File: rtl/ead_checker.sv
module ead_checker #(
    parameter int CODE_W  = 4,
    parameter int STRAP_W = 3,
    parameter logic [CODE_W-1:0] MEM_CODE  = 4'b1010,
    parameter logic [CODE_W-1:0] PROT_CODE = 4'b0110,
    localparam int BYTE_W = CODE_W + STRAP_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               start_det,
    input logic               stop_det,
    input logic               byte_vld,
    input logic [BYTE_W-1:0]  byte_data,
    input logic [STRAP_W-1:0] strap,
    input logic               wr_busy,
    input logic               prot_set,
    input logic               ack_vld,
    input logic               ack_n,
    input logic [1:0]         tgt_sel,
    input logic               op_rd
);
    logic acked;
    assign acked = ack_vld && !ack_n;

    assert_pulse_follows_byte_R2: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> $past(byte_vld));

    assert_strap_matched_R4: assert property (@(posedge clk) disable iff (rst)
        acked |-> $past(byte_data[STRAP_W:1] == strap));

    assert_mem_code_and_dir_R3: assert property (@(posedge clk) disable iff (rst)
        (acked && tgt_sel == 2'b01) |->
            ($past(byte_data[BYTE_W-1 -: CODE_W] == MEM_CODE) && op_rd == $past(byte_data[0])));

    assert_prot_write_only_R5: assert property (@(posedge clk) disable iff (rst)
        (acked && tgt_sel == 2'b10) |->
            ($past(byte_data[BYTE_W-1 -: CODE_W] == PROT_CODE) && $past(!byte_data[0]) && !op_rd));

    assert_prot_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (acked && tgt_sel == 2'b10) |-> $past(!prot_set));

    assert_busy_refuses_R7: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> (ack_n || $past(!wr_busy)));

    assert_ack_has_target_R8: assert property (@(posedge clk) disable iff (rst)
        acked |-> (tgt_sel == 2'b01 || tgt_sel == 2'b10));

    assert_bound_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (start_det || stop_det) |=> (!ack_vld && tgt_sel == 2'b00 && !op_rd));
endmodule

bind ee_addr_decoder ead_checker #(
    .CODE_W   (CODE_W),
    .STRAP_W  (STRAP_W),
    .MEM_CODE (MEM_CODE),
    .PROT_CODE(PROT_CODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_det(start_det),
    .stop_det (stop_det),
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .strap    (strap),
    .wr_busy  (wr_busy),
    .prot_set (prot_set),
    .ack_vld  (ack_vld),
    .ack_n    (ack_n),
    .tgt_sel  (tgt_sel),
    .op_rd    (op_rd)
);

// File: tb/ee_addr_decoder_bench.sv
module ee_addr_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [2:0] strap = 3'b000;
    logic       wr_busy = 1'b0;
    logic       prot_set = 1'b0;
    logic       ack_vld;
    logic       ack_n;
    logic [1:0] tgt_sel;
    logic       op_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ee_addr_decoder u_ee_addr_decoder (
        .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .byte_data(byte_data), .strap(strap),
        .wr_busy(wr_busy), .prot_set(prot_set), .ack_vld(ack_vld),
        .ack_n(ack_n), .tgt_sel(tgt_sel), .op_rd(op_rd)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {ack_vld,ack_n,tgt_sel,op_rd} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {ack_vld, ack_n, tgt_sel, op_rd};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_det = 1'b1; step(); start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_det = 1'b1; step(); stop_det = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_data = b; byte_vld = 1'b1; step(); byte_vld = 1'b0;
    endtask

    task automatic run_case(input logic [7:0] b, input logic [2:0] s, input logic busy, input logic prot);
        logic [3:0] code;
        logic       hit;
        logic [1:0] etgt;
        logic       erd;
        string      tag;
        code = b[7:4];
        hit  = !busy && (b[3:1] == s) &&
               (code == 4'b1010 || (code == 4'b0110 && !b[0] && !prot));
        etgt = !hit ? 2'b00 : (code == 4'b1010 ? 2'b01 : 2'b10);
        erd  = hit && code == 4'b1010 && b[0];
        if (busy)                 tag = "R7";
        else if (b[3:1] != s)     tag = "R4";
        else if (code == 4'b1010) tag = "R3";
        else if (code == 4'b0110) tag = prot ? "R6" : "R5";
        else                      tag = "R8";
        strap = s; wr_busy = busy; prot_set = prot;
        pulse_start();
        send_byte(b);
        check({tag, " R2 decision"}, outs(), {1'b1, !hit, etgt, erd});
        send_byte(b);
        check({tag, " R10 later byte"}, outs(), {1'b0, 1'b1, etgt, erd});
        pulse_stop();
        check("R9 stop clears", outs(), {1'b0, 1'b1, 2'b00, 1'b0});
    endtask

    initial begin
        repeat (3) step();
        check("R1 reset", outs(), 5'b0_1_00_0);
        rst = 1'b0;
        step();
        check("R1 after release", outs(), 5'b0_1_00_0);

        for (int s = 0; s < 8; s++)
            for (int b = 0; b < 256; b++)
                for (int f = 0; f < 4; f++)
                    run_case(8'(b), 3'(s), f[0], f[1]);

        strap = 3'b101; wr_busy = 1'b0; prot_set = 1'b0;
        send_byte(8'b1010_101_1);
        check("R9 byte after stop ignored", outs(), 5'b0_1_00_0);

        pulse_start();
        start_det = 1'b1; byte_data = 8'b1010_101_0; byte_vld = 1'b1; step();
        start_det = 1'b0; byte_vld = 1'b0;
        check("R9 byte colliding with start", outs(), 5'b0_1_00_0);
        send_byte(8'b1010_101_1);
        check("R9 decode after collision", outs(), 5'b1_0_01_1);

        pulse_start();
        check("R9 repeated start clears", outs(), 5'b0_1_00_0);
        send_byte(8'b0110_101_0);
        check("R5 protect after repeated start", outs(), 5'b1_0_10_0);

        pulse_start();
        send_byte(8'b1010_100_0);
        check("R4 refused", outs(), 5'b1_1_00_0);
        send_byte(8'b1010_101_0);
        check("R4 standby until start", outs(), 5'b0_1_00_0);

        pulse_start();
        wr_busy = 1'b1;
        send_byte(8'b1010_101_0);
        check("R7 poll while busy", outs(), 5'b1_1_00_0);
        wr_busy = 1'b0;
        pulse_start();
        send_byte(8'b1010_101_0);
        check("R7 poll after busy", outs(), 5'b1_0_01_0);
        pulse_stop();

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule